// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This block moves 8-bit channels between serial time-division streams. Every frame holds `CH` channels of eight bits on each of `STREAMS` input and output lines, one bit per clock with the most significant bit first. The channel count is 32, 64 or 128 for stream rates of 2.048, 4.096 or 8.192 Mb/s at an 8 kHz frame rate. Each input lane assembles its bits into bytes. Each completed byte is written into one of two data-memory banks. The banks swap roles at every frame boundary.

A connection memory holds one 16-bit entry for each output slot, split into a high and a low byte. Just before an output slot starts, its entry selects a source stream and a source channel, or it selects message mode. In message mode the low byte itself is sent. The entry also carries a per-slot drive enable, a control-line bit and a delay-mode bit. Constant-delay slots always carry data from the previous frame, so a wideband group keeps its order inside one output frame. Variable-delay slots take the current frame's byte whenever it has already arrived. A global drive-enable input gates every output driver at once. Drivers are modelled as a data bit and an active-high enable, so a pad cell can build the tristate.

Top module: `tsi_switch_core`

## Requirements
- R1: After reset is released, the first clock is channel 0, bit 0 of a frame. A frame is `CH` channels of 8 clocks each, and inputs are sampled MSB first. The byte selected for output channel k appears on `tx_o` MSB first, in the 8 clocks of output channel k.
- R2: A write with `cm_wr_i` high stores `cm_data_i` into the entry of stream `cm_stream_i`, channel `cm_chan_i`, from the next clock on. The high byte is written when `cm_hi_i`=1 and the low byte otherwise.
- R3: The delay-mode bit is high-byte bit 3, and 0 selects variable delay. A variable-delay slot k whose source channel is below k carries the source byte of the same frame. Any other variable-delay slot carries the source byte of the previous frame.
- R4: When high-byte bit 3 is 1 (constant delay), the slot carries the source byte of the previous frame whatever the source channel.
- R5: When high-byte bit 1 (message) is 1, the slot carries the low byte of its own entry instead of switched data.
- R6: When high-byte bit 0 (slot enable) is 0, `tx_en_o` of that stream is low for all 8 clocks of the slot. When it is 1, `tx_en_o` is high for all 8 clocks, provided the global enable is high.
- R7: While `odrv_en_i` is low, every bit of `tx_en_o` is low in the same cycle, whatever the memory contents.
- R8: High-byte bit 2 appears on `ctrl_o` of that stream during the slot it belongs to, independent of both enables.
- R9: The source stream is {high bit 4, low bits 7:5} and the source channel is {high bits 6:5, low bits 4:0}. Only the low log2(`STREAMS`) stream bits and the low log2(`CH`) channel bits are used.
- R10: During reset, `tx_o`, `tx_en_o` and `ctrl_o` are all 0. Reset also clears the connection memory, so every slot stays disabled until it is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | STREAMS | Serial input lines |
| odrv_en_i | input | 1 | Global output drive enable |
| cm_wr_i | input | 1 | Connection memory write strobe |
| cm_hi_i | input | 1 | 1 selects the high byte, 0 the low byte |
| cm_stream_i | input | log2(STREAMS) | Output stream of the entry written |
| cm_chan_i | input | log2(CH) | Output channel of the entry written |
| cm_data_i | input | 8 | Byte written to the entry |
| tx_o | output | STREAMS | Serial output data |
| tx_en_o | output | STREAMS | Output driver enable per stream |
| ctrl_o | output | STREAMS | Per-slot control bit per stream |

## Verification
A wrong bank pointer or a wrong bank choice shows as a byte from the wrong frame. This becomes visible on the first slot after a frame boundary that falls on the delay rule, so at most one frame of 8·`CH` clocks late. A misaligned slot counter or a bad bypass of the byte being written shows within one 8-clock slot, as a shifted or stale byte on the stream that reads it. A corrupted connection entry shows within a frame as a wrong byte, a wrong enable or a wrong control bit in that one slot. The global enable is combinational, so an error in it shows in the same cycle.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  // High byte of a connection entry; bit 7 of the written byte is unused.
  typedef struct packed {
    logic [1:0] ch_hi;     // source channel bits 6:5
    logic       strm_hi;   // source stream bit 3
    logic       const_dly; // 1: constant delay, 0: variable delay
    logic       ctrl;      // per-slot control line value
    logic       msg;       // 1: send the low byte itself
    logic       oe;        // per-slot drive enable
  } cm_hi_t;

  // Channel following ch in a frame of nch channels.
  function automatic logic [6:0] next_slot(input logic [6:0] ch, input int nch);
    return (int'(ch) == nch - 1) ? 7'd0 : ch + 7'd1;
  endfunction

  // 1 when the slot must read the bank filled during the previous frame.
  function automatic logic read_prev_bank(input logic const_dly,
                                          input logic [6:0] src_ch,
                                          input logic [6:0] out_ch);
    return const_dly || (src_ch >= out_ch);
  endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int CH = 32,
  localparam int CW = $clog2(CH)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] ch_o,
  output logic          wbank_o,
  output logic          slot_end_o,
  output logic          frame_end_o,
  output logic [CW-1:0] next_ch_o,
  output logic          out_bank_o
);
  logic [2:0]    bit_q;
  logic [CW-1:0] ch_q;
  logic          bank_q;

  assign slot_end_o  = (bit_q == 3'd7);
  assign frame_end_o = slot_end_o && (int'(ch_q) == CH - 1);
  assign next_ch_o   = CW'(tsi_pkg::next_slot(7'(ch_q), CH));
  // Bank receiving the frame that the next output slot belongs to.
  assign out_bank_o  = frame_end_o ? ~bank_q : bank_q;
  assign ch_o        = ch_q;
  assign wbank_o     = bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= '0;
      ch_q   <= '0;
      bank_q <= 1'b0;
    end else begin
      bit_q <= bit_q + 3'd1;
      if (slot_end_o) ch_q <= next_ch_o;
      if (frame_end_o) bank_q <= ~bank_q;
    end
  end

  assert_bit_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    slot_end_o |=> (bit_q == 3'd0));
  assert_bank_swap_R4: assert property (@(posedge clk) disable iff (rst)
    (bank_q != $past(bank_q)) |-> $past(frame_end_o));
  assert_chan_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !slot_end_o |=> $stable(ch_q));
endmodule

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx,
  output logic [7:0] byte_o
);
  logic [6:0] sh_q;

  // Completed byte is valid in the last bit of a slot.
  assign byte_o = {sh_q, rx};

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[5:0], rx};
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int STREAMS = 4,
  parameter int CH = 32,
  localparam int SW = $clog2(STREAMS),
  localparam int CW = $clog2(CH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [CW-1:0] wr_ch,
  input  logic [7:0]    wr_byte [STREAMS],
  input  logic          rd_bank [STREAMS],
  input  logic [SW-1:0] rd_st   [STREAMS],
  input  logic [CW-1:0] rd_ch   [STREAMS],
  output logic [7:0]    rd_byte [STREAMS]
);
  logic [7:0] mem_q [2][STREAMS][CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < STREAMS; s++)
          for (int c = 0; c < CH; c++)
            mem_q[b][s][c] <= '0;
    end else if (wr_en) begin
      for (int s = 0; s < STREAMS; s++)
        mem_q[wr_bank][s][wr_ch] <= wr_byte[s];
    end
  end

  for (genvar r = 0; r < STREAMS; r++) begin : g_rd
    logic hit;
    // Byte landing on this very edge is forwarded to the reader.
    assign hit = wr_en && (rd_bank[r] == wr_bank) && (rd_ch[r] == wr_ch);
    assign rd_byte[r] = hit ? wr_byte[rd_st[r]] : mem_q[rd_bank[r]][rd_st[r]][rd_ch[r]];
  end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int STREAMS = 4,
  parameter int CH = 32,
  localparam int SW = $clog2(STREAMS),
  localparam int CW = $clog2(CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_hi,
  input  logic [SW-1:0]   wr_st,
  input  logic [CW-1:0]   wr_ch,
  input  logic [7:0]      wr_data,
  input  logic [CW-1:0]   rd_ch,
  output tsi_pkg::cm_hi_t hi_o [STREAMS],
  output logic [7:0]      lo_o [STREAMS]
);
  tsi_pkg::cm_hi_t hi_q [STREAMS][CH];
  logic [7:0]      lo_q [STREAMS][CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STREAMS; s++)
        for (int c = 0; c < CH; c++) begin
          hi_q[s][c] <= '0;
          lo_q[s][c] <= '0;
        end
    end else if (wr_en) begin
      if (wr_hi) hi_q[wr_st][wr_ch] <= tsi_pkg::cm_hi_t'(wr_data[6:0]);
      else       lo_q[wr_st][wr_ch] <= wr_data;
    end
  end

  for (genvar s = 0; s < STREAMS; s++) begin : g_rd
    assign hi_o[s] = hi_q[s][rd_ch];
    assign lo_o[s] = lo_q[s][rd_ch];
  end

  assert_cm_write_hi_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hi) |=> (7'(hi_q[$past(wr_st)][$past(wr_ch)]) == $past(wr_data[6:0])));
  assert_cm_write_lo_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hi) |=> (lo_q[$past(wr_st)][$past(wr_ch)] == $past(wr_data)));
endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] byte_i,
  input  logic       oe,
  input  logic       ctrl,
  input  logic       odrv_en,
  output logic       tx,
  output logic       tx_en,
  output logic       ctrl_o
);
  logic [7:0] sh_q;
  logic       en_q;
  logic       ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      en_q   <= 1'b0;
      ctrl_q <= 1'b0;
    end else if (load) begin
      sh_q   <= byte_i;
      en_q   <= oe;
      ctrl_q <= ctrl;
    end else begin
      sh_q <= {sh_q[6:0], 1'b0};
    end
  end

  assign tx     = sh_q[7];
  assign tx_en  = en_q & odrv_en;
  assign ctrl_o = ctrl_q;

  assert_tx_shift_R1: assert property (@(posedge clk) disable iff (rst)
    !load |=> (sh_q == {$past(sh_q[6:0]), 1'b0}));
  assert_slot_en_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(en_q));
endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core #(
  parameter int STREAMS = 4,
  parameter int CH = 32,
  localparam int SW = $clog2(STREAMS),
  localparam int CW = $clog2(CH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STREAMS-1:0] rx_i,
  input  logic               odrv_en_i,
  input  logic               cm_wr_i,
  input  logic               cm_hi_i,
  input  logic [SW-1:0]      cm_stream_i,
  input  logic [CW-1:0]      cm_chan_i,
  input  logic [7:0]         cm_data_i,
  output logic [STREAMS-1:0] tx_o,
  output logic [STREAMS-1:0] tx_en_o,
  output logic [STREAMS-1:0] ctrl_o
);
  logic [CW-1:0]   cur_ch, next_ch;
  logic            wbank, slot_end, frame_end, out_bank;
  logic [7:0]      wr_bytes [STREAMS];
  logic            rd_bank  [STREAMS];
  logic [SW-1:0]   rd_st    [STREAMS];
  logic [CW-1:0]   rd_ch    [STREAMS];
  logic [7:0]      rd_byte  [STREAMS];
  tsi_pkg::cm_hi_t hi_rd    [STREAMS];
  logic [7:0]      lo_rd    [STREAMS];

  tsi_timing #(.CH(CH)) u_timing (
    .clk(clk), .rst(rst), .ch_o(cur_ch), .wbank_o(wbank),
    .slot_end_o(slot_end), .frame_end_o(frame_end),
    .next_ch_o(next_ch), .out_bank_o(out_bank)
  );

  for (genvar s = 0; s < STREAMS; s++) begin : g_rx
    tsi_rx_lane u_rx (.clk(clk), .rst(rst), .rx(rx_i[s]), .byte_o(wr_bytes[s]));
  end

  tsi_data_mem #(.STREAMS(STREAMS), .CH(CH)) u_dmem (
    .clk(clk), .rst(rst), .wr_en(slot_end), .wr_bank(wbank), .wr_ch(cur_ch),
    .wr_byte(wr_bytes), .rd_bank(rd_bank), .rd_st(rd_st), .rd_ch(rd_ch),
    .rd_byte(rd_byte)
  );

  tsi_conn_mem #(.STREAMS(STREAMS), .CH(CH)) u_cmem (
    .clk(clk), .rst(rst), .wr_en(cm_wr_i), .wr_hi(cm_hi_i), .wr_st(cm_stream_i),
    .wr_ch(cm_chan_i), .wr_data(cm_data_i), .rd_ch(next_ch),
    .hi_o(hi_rd), .lo_o(lo_rd)
  );

  for (genvar o = 0; o < STREAMS; o++) begin : g_tx
    logic [6:0] src_ch_full;
    logic [3:0] src_st_full;
    logic       use_prev;
    logic [7:0] load_byte;

    assign src_ch_full = {hi_rd[o].ch_hi, lo_rd[o][4:0]};
    assign src_st_full = {hi_rd[o].strm_hi, lo_rd[o][7:5]};
    assign rd_ch[o]    = CW'(src_ch_full);
    assign rd_st[o]    = SW'(src_st_full);
    assign use_prev    = tsi_pkg::read_prev_bank(hi_rd[o].const_dly, 7'(rd_ch[o]), 7'(next_ch));
    assign rd_bank[o]  = use_prev ? ~out_bank : out_bank;
    assign load_byte   = hi_rd[o].msg ? lo_rd[o] : rd_byte[o];

    tsi_tx_lane u_tx (
      .clk(clk), .rst(rst), .load(slot_end), .byte_i(load_byte),
      .oe(hi_rd[o].oe), .ctrl(hi_rd[o].ctrl), .odrv_en(odrv_en_i),
      .tx(tx_o[o]), .tx_en(tx_en_o[o]), .ctrl_o(ctrl_o[o])
    );

    assert_msg_byte_R5: assert property (@(posedge clk) disable iff (rst)
      (slot_end && hi_rd[o].msg) |=> (tx_o[o] == $past(lo_rd[o][7])));
    assert_ctrl_follow_R8: assert property (@(posedge clk) disable iff (rst)
      slot_end |=> (ctrl_o[o] == $past(hi_rd[o].ctrl)));
  end

  assert_global_hiz_R7: assert property (@(posedge clk) disable iff (rst)
    !odrv_en_i |-> (tx_en_o == '0));
endmodule

// File: tb/tsi_switch_core_tb.sv
`timescale 1ns/100ps
module tsi_switch_core_tb_top;
  localparam int STREAMS = 4;
  localparam int CH = 32;
  localparam int SW = 2;
  localparam int CW = 5;
  localparam int FRAME = CH * 8;
  localparam int NFR = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [STREAMS-1:0] rx_i = '0;
  logic odrv_en_i = 1'b0;
  logic cm_wr_i = 1'b0, cm_hi_i = 1'b0;
  logic [SW-1:0] cm_stream_i = '0;
  logic [CW-1:0] cm_chan_i = '0;
  logic [7:0] cm_data_i = '0;
  logic [STREAMS-1:0] tx_o, tx_en_o, ctrl_o;

  int checks = 0;
  int errors = 0;
  bit running = 0;
  bit done = 0;
  int mpos = 0;

  typedef struct {
    int         o;
    logic       en;
    logic [7:0] b;
    logic       ctl;
    string      tag_en;
    string      tag_dat;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  tsi_switch_core #(.STREAMS(STREAMS), .CH(CH)) dut_i (
    .clk(clk), .rst(rst), .rx_i(rx_i), .odrv_en_i(odrv_en_i),
    .cm_wr_i(cm_wr_i), .cm_hi_i(cm_hi_i), .cm_stream_i(cm_stream_i),
    .cm_chan_i(cm_chan_i), .cm_data_i(cm_data_i),
    .tx_o(tx_o), .tx_en_o(tx_en_o), .ctrl_o(ctrl_o)
  );

  function automatic logic [7:0] pat(int f, int s, int c);
    return 8'((f * 37 + s * 71 + c * 13 + 5) & 255);
  endfunction

  // Per-slot settings: enable, message, control, constant, stream field, channel field.
  function automatic void cfg(input int o, input int k, output bit oe, output bit msg,
                              output bit ctl, output bit cst, output int st, output int ch);
    oe = 1; msg = 0; ctl = 0; cst = 0; st = 0; ch = 0;
    case (o)
      0: begin st = k % 4; ch = (k + 5) % 32; ctl = k[0]; end
      1: begin st = 3 - (k % 4); ch = 31 - k; cst = 1; end
      2: if (k % 3 == 0) begin msg = 1; ctl = 1; end
         else begin st = 1; ch = k; end
      default: begin st = 10; ch = ((k + 31) % 32) + 32; oe = (k % 4 != 1); ctl = !k[0]; end
    endcase
  endfunction

  function automatic logic [15:0] entry(int o, int k);
    bit oe, msg, ctl, cst; int st, ch;
    logic [7:0] hi, lo;
    cfg(o, k, oe, msg, ctl, cst, st, ch);
    hi = {1'b0, 2'(ch >> 5), 1'((st >> 3) & 1), cst, ctl, msg, oe};
    lo = msg ? (8'(k) ^ 8'hA5) : {3'(st & 7), 5'(ch & 31)};
    return {hi, lo};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver side of the scoreboard: expected items for output slot k of frame f.
  task automatic push_expected(int f, int k);
    for (int o = 0; o < STREAMS; o++) begin
      bit oe, msg, ctl, cst; int st, ch, sf;
      item_t it;
      cfg(o, k, oe, msg, ctl, cst, st, ch);
      st = st % STREAMS;   // R9: only low stream bits count
      ch = ch % CH;        // R9: only low channel bits count
      it.o = o;
      it.en = oe && (f != 5);
      it.ctl = ctl;
      it.tag_en = (f == 5) ? "R7" : "R6";
      if (msg) begin
        it.b = 8'(k) ^ 8'hA5;
        it.tag_dat = "R5 R2";
      end else begin
        sf = (cst || ch >= k) ? f - 1 : f;
        it.b = pat(sf, st, ch);
        it.tag_dat = cst ? "R4 R1" : ((o == 3) ? "R9 R3" : "R3 R1 R2");
      end
      sb_q.push_back(it);
    end
  endtask

  logic       acc_all [STREAMS];
  logic       acc_any [STREAMS];
  logic [7:0] acc_b   [STREAMS];

  // Monitor side: gathers each slot and compares against the queue.
  always @(negedge clk) begin
    if (running) begin
      int f, b;
      f = mpos / FRAME;
      b = mpos % 8;
      for (int o = 0; o < STREAMS; o++) begin
        if (b == 0) begin acc_all[o] = 1'b1; acc_any[o] = 1'b0; acc_b[o] = '0; end
        acc_all[o] = acc_all[o] & tx_en_o[o];
        acc_any[o] = acc_any[o] | tx_en_o[o];
        acc_b[o] = {acc_b[o][6:0], tx_o[o]};
      end
      if (b == 7 && f >= 2) begin
        for (int o = 0; o < STREAMS; o++) begin
          item_t it;
          if (sb_q.size() == 0) begin
            check("R1", 0, 1, "scoreboard empty");
          end else begin
            it = sb_q.pop_front();
            if (it.en) check(it.tag_en, 32'(acc_all[o]), 1, "slot enable");
            else       check(it.tag_en, 32'(acc_any[o]), 0, "slot disabled");
            if (it.en) check(it.tag_dat, 32'(acc_b[o]), 32'(it.b), "slot byte");
            check("R8", 32'(ctrl_o[o]), 32'(it.ctl), "control bit");
          end
        end
      end
      mpos++;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R10: reset state of all outputs
    check("R10", 32'(tx_en_o), 0, "enable in reset");
    check("R10", 32'(tx_o), 0, "data in reset");
    check("R10", 32'(ctrl_o), 0, "control in reset");
    rst = 1'b0;
    running = 1;
    for (int n = 0; n < NFR * FRAME; n++) begin
      int f, k, b;
      @(negedge clk);
      f = n / FRAME; k = (n / 8) % CH; b = n % 8;
      for (int s = 0; s < STREAMS; s++) rx_i[s] = pat(f, s, k)[7 - b];
      if (f == 0) begin
        logic [15:0] e;
        e = entry(n / 64, (n / 2) % CH);
        cm_wr_i = 1'b1;
        cm_hi_i = n[0];
        cm_stream_i = SW'(n / 64);
        cm_chan_i = CW'((n / 2) % CH);
        cm_data_i = n[0] ? e[15:8] : e[7:0];
      end else begin
        cm_wr_i = 1'b0;
      end
      if (b == 0 && f >= 2) push_expected(f, k);
      #1;
      odrv_en_i = ((n + 1) / FRAME >= 2) && ((n + 1) / FRAME != 5);
      if (f == 6 && k == 3 && b == 4) begin
        #0.5 odrv_en_i = 1'b0;
        #0.2 check("R7", 32'(tx_en_o), 0, "global disable same cycle");
        #0.1 odrv_en_i = 1'b1;
      end
    end
    @(negedge clk);
    running = 0;
    check("R1", 32'(sb_q.size()), 0, "scoreboard drained");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule